// File: doc/BRIEF.md
# Lifecycle Fuse Access Policy Unit

This block decides whether a read or a write to one region of a secure serial memory's configuration area is allowed. It holds three one-way lifecycle fuses: the fabrication fuse, the card-maker fuse and the personalisation fuse. These fuses are blown in a fixed order as the part moves from the silicon vendor to the card maker, then to the issuer, then to the field. The block also holds two session flags. One records that the secure code has been verified. The other records that the write password has been verified.

The protocol engine gives the block a region code and an operation type. It gets back a permit bit in the same cycle. The permit bit depends on the current lifecycle stage and on the session flags. The password checker raises a one-cycle pulse on `sc_ok` or `wpw_ok` after a successful comparison, and that pulse latches the matching flag. A reset pulse clears both flags and leaves the fuses as they are. A status byte reports the three fuses.

Top module: `fpol_unit`

## Requirements
- R1: After the first reset, `fuse_status` reads 0x07 and both session flags are clear.
- R2: `fuse_status` has the fabrication fuse in bit 0, the card-maker fuse in bit 1 and the personalisation fuse in bit 2. A 1 means intact. Bits 7..3 always read 0.
- R3: `blow_sel` selects the fuse: 0 = fabrication, 1 = card-maker, 2 = personalisation. A one-cycle `blow_req` clears the selected bit, visible after the next clock edge, only if the fuse before it in that order is already blown. The fabrication fuse has no predecessor. Any other request, including `blow_sel` = 3, leaves `fuse_status` unchanged.
- R4: A blown fuse never reads 1 again. This holds across `rst`.
- R5: A pulse on `sc_ok` sets the secure-code flag, and a pulse on `wpw_ok` sets the write-password flag, each from the next cycle on. `rst` clears both flags and wins over a set pulse in the same cycle.
- R6: While all three fuses are intact, `permit` is 1 for every region and operation.
- R7: Region codes on `req_region` are: 0 fabrication data, 1 maker code, 2 access registers, 3 test byte, 4 identification, 5 secret, 6 passwords, 7 attempt counters. `req_write` = 1 means write. Once any fuse is blown, the test byte is always permitted, and fabrication data can be read but never written.
- R8: Maker-code reads are always permitted. Maker-code writes need the secure-code flag while only the fabrication fuse is blown, and are refused once the card-maker fuse is blown.
- R9: Access-register and identification reads are always permitted. Writes to them need the secure-code flag until the personalisation fuse is blown, and are refused after that.
- R10: Secret reads and writes need the secure-code flag until the personalisation fuse is blown, and are refused after that.
- R11: Password reads and writes need the secure-code flag before the personalisation fuse is blown. After it is blown they need the write-password flag, and the secure-code flag alone no longer grants them.
- R12: Attempt-counter reads are always permitted. Attempt-counter writes follow the same flag rule as the password region.
- R13: `permit` is combinational from the registered fuse and flag state. It is valid in the same cycle that `req_region` and `req_write` are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous session reset; clears both flags, fuses untouched |
| blow_req | input | 1 | Fuse blow request strobe |
| blow_sel | input | 2 | Fuse selector for the blow request |
| sc_ok | input | 1 | Pulse: secure code verified |
| wpw_ok | input | 1 | Pulse: write password verified |
| req_region | input | 3 | Region code of the access being checked |
| req_write | input | 1 | 1 = write, 0 = read |
| permit | output | 1 | Access allowed |
| fuse_status | output | 8 | Fuse status byte |

## Verification
The bench builds the block with its default parameters: three fuses and an eight-bit status byte. With three fuses the legal lifecycle has only four stages, so the whole permission space can be swept. At every stage the bench covers all eight regions, both operations and all four session-flag combinations, which gives 64 cases per stage. Expected permits come from a bench-side rule function. Directed steps cover out-of-order and repeated blow requests, the unused selector code, fuse persistence across reset, and reset winning over a simultaneous flag-set pulse.

// File: rtl/fpol_pkg.sv
package fpol_pkg;
  localparam int FUSE_N   = 3;
  localparam int STATUS_W = 8;
  localparam int SEL_W    = 2;
  localparam int REGION_W = 3;

  typedef enum logic [REGION_W-1:0] {
    RGN_FABDATA = 3'd0,
    RGN_MFRCODE = 3'd1,
    RGN_ACCREG  = 3'd2,
    RGN_TEST    = 3'd3,
    RGN_IDENT   = 3'd4,
    RGN_SECRET  = 3'd5,
    RGN_PASSWD  = 3'd6,
    RGN_COUNTER = 3'd7
  } region_e;

  typedef enum logic [1:0] {
    STG_OPEN,
    STG_MAKER,
    STG_ISSUER,
    STG_FIELD
  } stage_e;

  typedef struct packed {
    logic sc;
    logic wp;
  } session_t;
endpackage

// File: rtl/fpol_fuse_bank.sv
module fpol_fuse_bank
  import fpol_pkg::*;
#(
  parameter int N  = FUSE_N,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          blow_req,
  input  logic [SW-1:0] blow_sel,
  output logic [N-1:0]  fuse_q
);
  for (genvar i = 0; i < N; i++) begin : g_fuse
    logic bit_q = 1'b1;
    logic pred_blown;
    if (i == 0) begin : g_first
      assign pred_blown = 1'b1;
    end else begin : g_chain
      assign pred_blown = ~fuse_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (blow_req && (blow_sel == SW'(i)) && pred_blown)
        bit_q <= 1'b0;
    end
    assign fuse_q[i] = bit_q;
  end
endmodule

// File: rtl/fpol_session.sv
module fpol_session
  import fpol_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sc_set,
  input  logic     wp_set,
  output session_t sess
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sess <= '0;
    end else begin
      if (sc_set) sess.sc <= 1'b1;
      if (wp_set) sess.wp <= 1'b1;
    end
  end
endmodule

// File: rtl/fpol_rules.sv
module fpol_rules
  import fpol_pkg::*;
(
  input  logic [FUSE_N-1:0] fuse,
  input  region_e           region,
  input  logic              wr,
  input  session_t          sess,
  output logic              permit
);
  stage_e stage;
  logic   pre_pers;
  logic   pw_grant;

  always_comb begin
    if (!fuse[2])      stage = STG_FIELD;
    else if (!fuse[1]) stage = STG_ISSUER;
    else if (!fuse[0]) stage = STG_MAKER;
    else               stage = STG_OPEN;
  end

  assign pre_pers = (stage != STG_FIELD);
  assign pw_grant = pre_pers ? sess.sc : sess.wp;

  always_comb begin
    permit = 1'b0;
    if (stage == STG_OPEN) begin
      permit = 1'b1;
    end else begin
      case (region)
        RGN_FABDATA: permit = !wr;
        RGN_MFRCODE: permit = !wr || (stage == STG_MAKER && sess.sc);
        RGN_ACCREG,
        RGN_IDENT:   permit = !wr || (pre_pers && sess.sc);
        RGN_TEST:    permit = 1'b1;
        RGN_SECRET:  permit = pre_pers && sess.sc;
        RGN_PASSWD:  permit = pw_grant;
        RGN_COUNTER: permit = !wr || pw_grant;
        default:     permit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fpol_unit.sv
module fpol_unit
  import fpol_pkg::*;
#(
  parameter int NUM_FUSES = FUSE_N,
  parameter int STAT_W    = STATUS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                blow_req,
  input  logic [SEL_W-1:0]    blow_sel,
  input  logic                sc_ok,
  input  logic                wpw_ok,
  input  logic [REGION_W-1:0] req_region,
  input  logic                req_write,
  output logic                permit,
  output logic [STAT_W-1:0]   fuse_status
);
  localparam int PAD_W = STAT_W - NUM_FUSES;

  logic [NUM_FUSES-1:0] fuse_q;
  session_t             sess;

  fpol_fuse_bank #(.N(NUM_FUSES), .SW(SEL_W)) u_fuses (
    .clk      (clk),
    .blow_req (blow_req),
    .blow_sel (blow_sel),
    .fuse_q   (fuse_q)
  );

  fpol_session u_sess (
    .clk    (clk),
    .rst    (rst),
    .sc_set (sc_ok),
    .wp_set (wpw_ok),
    .sess   (sess)
  );

  fpol_rules u_rules (
    .fuse   (fuse_q),
    .region (region_e'(req_region)),
    .wr     (req_write),
    .sess   (sess),
    .permit (permit)
  );

  assign fuse_status = {{PAD_W{1'b0}}, fuse_q};
endmodule

// File: rtl/fpol_unit_chk.sv
module fpol_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] req_region,
  input logic       req_write,
  input logic       permit,
  input logic [7:0] fuse_status
);
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) fuse_status[7:3] == 5'd0); // R2
  AST_FAB_ONE_WAY: assert property (@(posedge clk) disable iff (rst) !fuse_status[0] |=> !fuse_status[0]); // R4
  AST_CMA_ONE_WAY: assert property (@(posedge clk) disable iff (rst) !fuse_status[1] |=> !fuse_status[1]); // R4
  AST_PER_ONE_WAY: assert property (@(posedge clk) disable iff (rst) !fuse_status[2] |=> !fuse_status[2]); // R4
  AST_BLOW_ORDER: assert property (@(posedge clk) disable iff (rst)
    fuse_status[2:0] inside {3'b111, 3'b110, 3'b100, 3'b000}); // R3
  AST_OPEN_STAGE: assert property (@(posedge clk) disable iff (rst) fuse_status[0] |-> permit); // R6
  AST_TEST_FREE: assert property (@(posedge clk) disable iff (rst) req_region == 3'd3 |-> permit); // R7
  AST_FABDATA_RO: assert property (@(posedge clk) disable iff (rst)
    (!fuse_status[0] && req_region == 3'd0 && req_write) |-> !permit); // R7
  AST_SECRET_SEALED: assert property (@(posedge clk) disable iff (rst)
    (!fuse_status[2] && req_region == 3'd5) |-> !permit); // R10
endmodule

bind fpol_unit fpol_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_region  (req_region),
  .req_write   (req_write),
  .permit      (permit),
  .fuse_status (fuse_status)
);

// File: tb/fpol_unit_test.sv
module fpol_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       blow_req = 1'b0;
  logic [1:0] blow_sel = 2'd0;
  logic       sc_ok = 1'b0;
  logic       wpw_ok = 1'b0;
  logic [2:0] req_region = 3'd0;
  logic       req_write = 1'b0;
  logic       permit;
  logic [7:0] fuse_status;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fpol_unit uut (
    .clk(clk), .rst(rst), .blow_req(blow_req), .blow_sel(blow_sel),
    .sc_ok(sc_ok), .wpw_ok(wpw_ok), .req_region(req_region),
    .req_write(req_write), .permit(permit), .fuse_status(fuse_status)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_permit(logic [2:0] f, int rg, bit wr, bit sc, bit wp);
    bit field = !f[2];
    bit only_fab = !f[0] && f[1];
    if (f == 3'b111) return 1'b1;
    case (rg)
      0: return !wr;
      1: return !wr || (only_fab && sc);
      2, 4: return !wr || (!field && sc);
      3: return 1'b1;
      5: return !field && sc;
      6: return field ? wp : sc;
      default: return !wr || (field ? wp : sc);
    endcase
  endfunction

  function automatic string tag(logic [2:0] f, int rg);
    if (f == 3'b111) return "R6";
    case (rg)
      0, 3: return "R7";
      1: return "R8";
      2, 4: return "R9";
      5: return "R10";
      6: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic blow(logic [1:0] sel);
    @(negedge clk); blow_req = 1'b1; blow_sel = sel;
    @(negedge clk); blow_req = 1'b0;
    #1;
  endtask

  task automatic set_session(bit sc, bit wp);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; sc_ok = sc; wpw_ok = wp;
    @(negedge clk); sc_ok = 1'b0; wpw_ok = 1'b0;
  endtask

  task automatic sweep(logic [2:0] f);
    for (int c = 0; c < 4; c++) begin
      set_session(c[0], c[1]);
      for (int rg = 0; rg < 8; rg++) begin
        for (int w = 0; w < 2; w++) begin
          req_region = 3'(rg); req_write = w[0];
          #1;
          chk($sformatf("%s R13 rg=%0d wr=%0d sc=%0d wp=%0d", tag(f, rg), rg, w, c[0], c[1]),
              {7'd0, permit}, {7'd0, exp_permit(f, rg, w[0], c[0], c[1])});
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 status", fuse_status, 8'h07);
    req_region = 3'd6; req_write = 1'b0;
    #1 chk("R1 session clear", {7'd0, permit}, 8'h01);
    sweep(3'b111);
    // R3: out-of-order and unused selector ignored
    blow(2'd1); chk("R3 cma before fab", fuse_status, 8'h07);
    blow(2'd2); chk("R3 per before fab", fuse_status, 8'h07);
    blow(2'd3); chk("R3 sel 3", fuse_status, 8'h07);
    blow(2'd0); chk("R3 fab blow", fuse_status, 8'h06);
    blow(2'd2); chk("R3 per before cma", fuse_status, 8'h06);
    blow(2'd0); chk("R4 fab reblow", fuse_status, 8'h06);
    set_session(1'b0, 1'b0);
    chk("R4 across rst", fuse_status, 8'h06);
    sweep(3'b110);
    // R5: flag latches, rst clears, rst wins
    set_session(1'b1, 1'b0);
    req_region = 3'd5; req_write = 1'b0;
    #1 chk("R5 sc latched", {7'd0, permit}, 8'h01);
    @(negedge clk); rst = 1'b1; sc_ok = 1'b1;
    @(negedge clk); rst = 1'b0; sc_ok = 1'b0;
    #1 chk("R5 rst wins", {7'd0, permit}, 8'h00);
    blow(2'd1); chk("R3 cma blow", fuse_status, 8'h04);
    sweep(3'b100);
    blow(2'd2); chk("R2 per blow", fuse_status, 8'h00);
    sweep(3'b000);
    blow(2'd0); chk("R4 all blown stay", fuse_status, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule